// File: doc/BRIEF.md
# Interrupt Return Sequencer

This block carries out the hardware side of a return from an interrupt or exception handler. A one-cycle start strobe hands it the handler's stack pointer, stack selector, privilege level and the four data segment selectors. It then reads words off the stack through a simple request/acknowledge memory port and rebuilds the processor state that was saved when the handler was entered. The stack must already be clear of any error code when the strobe arrives.

The first three stack words give back the instruction pointer, the code selector and the flags. The low two bits of the popped code selector are the level being returned to. If that level equals the handler's level, the return ends there and the stack pointer simply moves past the three words. If the levels differ, two more words are read: the outer stack pointer and then the outer stack selector. Each data segment register whose descriptor privilege is numerically below the new level is then forced to the null selector (zero). A one-cycle done strobe marks the point where every output holds its final value.

Top module: `irs_seq`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are 0, and ip_o, cs_o, flags_o, sp_o, ss_o, cpl_o and seg_o are all zero.
- R2: A start_i pulse while idle latches sp_i, ss_i, cpl_i and seg_i. Each stack read then uses one 32-bit word at mem_addr_o. The first read is at sp_i, and each accepted read advances the address by 4.
- R3: The first three stack words go, in this order, to ip_o, to cs_o (low 16 bits of the word) and to flags_o.
- R4: When cpl_i equals bits [1:0] of the popped code selector, exactly three reads are made. sp_o ends at sp_i + 12, and ss_o and seg_o keep the values latched at start.
- R5: When the levels differ, exactly five reads are made. The fourth word becomes sp_o and the low 16 bits of the fifth become ss_o.
- R6: At completion, cpl_o equals bits [1:0] of the popped code selector.
- R7: On a level change, data segment k (seg_i/seg_o bits [16k+15:16k], k = 0..3) is cleared to zero exactly when its descriptor privilege seg_dpl_i[2k+1:2k] is numerically less than the new level. Otherwise it keeps its latched value.
- R8: done_o is high for exactly one cycle, once all outputs hold their final values. busy_o drops in the cycle after done_o.
- R9: A start_i pulse while busy_o is high has no effect on the read sequence or on the results.
- R10: A read request stays asserted with a stable address until mem_ack_i is high in a clock cycle. Data is taken from mem_rdata_i in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a return (honoured only when idle) |
| sp_i | input | 32 | Handler stack pointer at return time |
| ss_i | input | 16 | Handler stack selector |
| cpl_i | input | 2 | Handler privilege level |
| seg_i | input | 64 | Four data segment selectors, 16 bits each |
| seg_dpl_i | input | 8 | Descriptor privilege of each data segment, 2 bits each |
| mem_req_o | output | 1 | Stack read request |
| mem_addr_o | output | 32 | Stack read address |
| mem_ack_i | input | 1 | Read accepted; data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Return in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ip_o | output | 32 | Restored instruction pointer |
| cs_o | output | 16 | Restored code selector |
| flags_o | output | 32 | Restored flags |
| sp_o | output | 32 | Resulting stack pointer |
| ss_o | output | 16 | Resulting stack selector |
| cpl_o | output | 2 | Resulting privilege level |
| seg_o | output | 64 | Data segment selectors after sanitising |

## Verification
The bench builds the block with its default parameters: 32-bit words, 16-bit selectors, 2-bit privilege levels and four data segments. At these sizes, every pairing of handler level and popped selector level can be crossed with all 256 combinations of the four descriptor privileges, so the same-level path and every clear mask on the level-change path are covered. The memory model's acknowledge delay rotates through 0, 1 and 2 cycles, which exercises back-to-back reads as well as held requests. On a share of the returns, an extra start pulse with a different stack pointer is sent in mid-sequence.

// File: rtl/irs_pkg.sv
package irs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POP,
    ST_SCRUB,
    ST_DONE
  } irs_state_e;

  // Stack slot order: reverse of the order used when the handler was entered.
  localparam logic [2:0] SLOT_IP = 3'd0;
  localparam logic [2:0] SLOT_CS = 3'd1;
  localparam logic [2:0] SLOT_FL = 3'd2;
  localparam logic [2:0] SLOT_SP = 3'd3;
  localparam logic [2:0] SLOT_SS = 3'd4;

  localparam int unsigned INNER_POPS = 3;
  localparam int unsigned OUTER_POPS = 5;

endpackage

// File: rtl/irs_pop_unit.sv
module irs_pop_unit #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          want_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          fire_o,
  output logic [2:0]    slot_o
);

  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [2:0]    slot_q, slot_d;
  logic          ptr_en;

  assign req_o  = want_i;
  assign fire_o = want_i & ack_i;
  assign addr_o = ptr_q;
  assign slot_o = slot_q;
  assign ptr_en = load_i | fire_o;

  always_comb begin
    ptr_d  = ptr_q;
    slot_d = slot_q;
    if (load_i) begin
      ptr_d  = load_addr_i;
      slot_d = irs_pkg::SLOT_IP;
    end else if (fire_o) begin
      ptr_d  = ptr_q + STEP_W;
      slot_d = slot_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      slot_q <= '0;
    end else if (ptr_en) begin
      ptr_q  <= ptr_d;
      slot_q <= slot_d;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (addr_o == $past(addr_o) + STEP_W)); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i && !load_i) |=> $stable(addr_o)); // R10

endmodule

// File: rtl/irs_priv_cmp.sv
module irs_priv_cmp #(
  parameter int unsigned PLW = 2
) (
  input  logic [PLW-1:0] handler_lvl_i,
  input  logic [PLW-1:0] sel_rpl_i,
  output logic           same_o,
  output logic [PLW-1:0] new_lvl_o
);

  assign same_o    = (handler_lvl_i == sel_rpl_i);
  assign new_lvl_o = sel_rpl_i;

endmodule

// File: rtl/irs_seg_scrub.sv
module irs_seg_scrub #(
  parameter int unsigned NSEG = 4,
  parameter int unsigned SELW = 16,
  parameter int unsigned PLW  = 2
) (
  input  logic [NSEG*SELW-1:0] seg_i,
  input  logic [NSEG*PLW-1:0]  dpl_i,
  input  logic [PLW-1:0]       lvl_i,
  output logic [NSEG*SELW-1:0] seg_o,
  output logic [NSEG-1:0]      clr_o
);

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [PLW-1:0] dpl_k;
    assign dpl_k    = dpl_i[k*PLW +: PLW];
    assign clr_o[k] = (dpl_k < lvl_i);
    assign seg_o[k*SELW +: SELW] = clr_o[k] ? '0 : seg_i[k*SELW +: SELW];
  end

endmodule

// File: rtl/irs_seq.sv
module irs_seq #(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 32,
  parameter int unsigned SELW = 16,
  parameter int unsigned PLW  = 2,
  parameter int unsigned NSEG = 4,
  parameter int unsigned STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [AW-1:0]        sp_i,
  input  logic [SELW-1:0]      ss_i,
  input  logic [PLW-1:0]       cpl_i,
  input  logic [NSEG*SELW-1:0] seg_i,
  input  logic [NSEG*PLW-1:0]  seg_dpl_i,
  output logic                 mem_req_o,
  output logic [AW-1:0]        mem_addr_o,
  input  logic                 mem_ack_i,
  input  logic [DW-1:0]        mem_rdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DW-1:0]        ip_o,
  output logic [SELW-1:0]      cs_o,
  output logic [DW-1:0]        flags_o,
  output logic [AW-1:0]        sp_o,
  output logic [SELW-1:0]      ss_o,
  output logic [PLW-1:0]       cpl_o,
  output logic [NSEG*SELW-1:0] seg_o
);

  import irs_pkg::*;

  localparam int unsigned SEGW = NSEG * SELW;
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  irs_state_e state_q, state_d;

  logic [DW-1:0]   ip_q, flags_q;
  logic [SELW-1:0] cs_q, ss_q, ss_d;
  logic [AW-1:0]   sp_q, sp_d;
  logic [PLW-1:0]  cpl_q, cpl_d;
  logic [SEGW-1:0] seg_q, seg_d;

  logic load, want, fire;
  logic [2:0] slot;
  logic same_lvl;
  logic [PLW-1:0] new_lvl;
  logic [SEGW-1:0] seg_clean;
  logic [NSEG-1:0] seg_clr;

  logic ip_en, cs_en, fl_en, sp_en, ss_en, cpl_en, seg_en;

  irs_pop_unit #(.AW(AW), .STEP(STEP)) u_pop (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_addr_i(sp_i),
    .want_i     (want),
    .ack_i      (mem_ack_i),
    .req_o      (mem_req_o),
    .addr_o     (mem_addr_o),
    .fire_o     (fire),
    .slot_o     (slot)
  );

  irs_priv_cmp #(.PLW(PLW)) u_cmp (
    .handler_lvl_i(cpl_q),
    .sel_rpl_i    (cs_q[PLW-1:0]),
    .same_o       (same_lvl),
    .new_lvl_o    (new_lvl)
  );

  irs_seg_scrub #(.NSEG(NSEG), .SELW(SELW), .PLW(PLW)) u_scrub (
    .seg_i(seg_q),
    .dpl_i(seg_dpl_i),
    .lvl_i(new_lvl),
    .seg_o(seg_clean),
    .clr_o(seg_clr)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    want    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          state_d = ST_POP;
        end
      end
      ST_POP: begin
        want = 1'b1;
        if (fire && slot == SLOT_FL && same_lvl) state_d = ST_DONE;
        else if (fire && slot == SLOT_SS)        state_d = ST_SCRUB;
      end
      ST_SCRUB: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Clock enables and data selection
  assign ip_en = fire && (slot == SLOT_IP);
  assign cs_en = fire && (slot == SLOT_CS);
  assign fl_en = fire && (slot == SLOT_FL);

  always_comb begin
    sp_en  = 1'b0;
    ss_en  = 1'b0;
    cpl_en = 1'b0;
    seg_en = 1'b0;
    sp_d   = sp_q;
    ss_d   = ss_q;
    cpl_d  = cpl_q;
    seg_d  = seg_q;
    if (load) begin
      sp_en  = 1'b1;
      ss_en  = 1'b1;
      cpl_en = 1'b1;
      seg_en = 1'b1;
      sp_d   = sp_i;
      ss_d   = ss_i;
      cpl_d  = cpl_i;
      seg_d  = seg_i;
    end else if (fl_en && same_lvl) begin
      sp_en  = 1'b1;
      cpl_en = 1'b1;
      sp_d   = mem_addr_o + STEP_W;
      cpl_d  = new_lvl;
    end else if (fire && slot == SLOT_SP) begin
      sp_en = 1'b1;
      sp_d  = mem_rdata_i[AW-1:0];
    end else if (fire && slot == SLOT_SS) begin
      ss_en = 1'b1;
      ss_d  = mem_rdata_i[SELW-1:0];
    end else if (state_q == ST_SCRUB) begin
      cpl_en = 1'b1;
      seg_en = 1'b1;
      cpl_d  = new_lvl;
      seg_d  = seg_clean;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q    <= '0;
      cs_q    <= '0;
      flags_q <= '0;
    end else begin
      if (ip_en) ip_q    <= mem_rdata_i;
      if (cs_en) cs_q    <= mem_rdata_i[SELW-1:0];
      if (fl_en) flags_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ss_q  <= '0;
      cpl_q <= '0;
      seg_q <= '0;
    end else begin
      if (sp_en)  sp_q  <= sp_d;
      if (ss_en)  ss_q  <= ss_d;
      if (cpl_en) cpl_q <= cpl_d;
      if (seg_en) seg_q <= seg_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign ip_o    = ip_q;
  assign cs_o    = cs_q;
  assign flags_o = flags_q;
  assign sp_o    = sp_q;
  assign ss_o    = ss_q;
  assign cpl_o   = cpl_q;
  assign seg_o   = seg_q;

  // Checker tally of accepted reads since the last start
  logic [2:0] chk_pops_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_pops_q <= '0;
    else if (load) chk_pops_q <= '0;
    else if (fire) chk_pops_q <= chk_pops_q + 3'd1;
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R8

  AST_LVL_FROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cpl_o == cs_o[PLW-1:0])); // R6

  AST_POP_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_pops_q == 3'(INNER_POPS) || chk_pops_q == 3'(OUTER_POPS))); // R5

  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o); // R9

endmodule

// File: tb/irs_seq_tb_top.sv
`timescale 1ns/1ps
module irs_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] sp_i;
  logic [15:0] ss_i;
  logic [1:0]  cpl_i;
  logic [63:0] seg_i;
  logic [7:0]  seg_dpl_i;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i;
  logic [31:0] mem_rdata_i;
  logic        busy_o, done_o;
  logic [31:0] ip_o, flags_o, sp_o;
  logic [15:0] cs_o, ss_o;
  logic [1:0]  cpl_o;
  logic [63:0] seg_o;

  irs_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i), .ss_i(ss_i),
    .cpl_i(cpl_i), .seg_i(seg_i), .seg_dpl_i(seg_dpl_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .ip_o(ip_o), .cs_o(cs_o), .flags_o(flags_o), .sp_o(sp_o), .ss_o(ss_o),
    .cpl_o(cpl_o), .seg_o(seg_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk;
  int n_bad;

  logic [31:0] mem [0:7];
  logic [31:0] base;
  int lat;
  int waitc;
  int rd_n;
  int addr_err;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: answers a request after lat idle cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack_i   = 1'b0;
      mem_rdata_i = '0;
      waitc       = 0;
    end else if (mem_req_o && waitc >= lat) begin
      if (mem_addr_o !== base + 32'(4 * rd_n)) addr_err++;
      mem_ack_i   = 1'b1;
      mem_rdata_i = mem[3'((mem_addr_o - base) >> 2)];
      rd_n++;
      waitc = 0;
    end else begin
      mem_ack_i   = 1'b0;
      mem_rdata_i = '0;
      if (mem_req_o) waitc++;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic run_one(input int hc, input int rpl, input int dpl, input int idx);
    logic [31:0] w_ip, w_cs, w_fl, w_sp, w_ss;
    logic [63:0] seg_in, seg_exp;
    logic [15:0] ss_in;
    int tmo;
    bit glitch;
    w_ip = 32'h1000_0000 ^ (32'(idx) * 32'h0000_9E37);
    w_cs = 32'hABCD_0000 | (32'(idx & 255) << 4) | 32'(rpl);
    w_fl = 32'h0000_0202 ^ (32'(idx) << 12);
    w_sp = 32'h00F0_0000 + 32'(idx * 16);
    w_ss = 32'h5A5A_0000 | 32'(idx & 16'hFFF0) | 32'h3;
    base = 32'h0000_8000 + 32'((idx % 16) * 64);
    mem[0] = w_ip; mem[1] = w_cs; mem[2] = w_fl; mem[3] = w_sp; mem[4] = w_ss;
    mem[5] = 32'hDEAD_0005; mem[6] = 32'hDEAD_0006; mem[7] = 32'hDEAD_0007;
    lat = idx % 3;
    glitch = (idx % 5 == 0);
    ss_in = 16'h7700 | 16'(idx & 255);
    for (int k = 0; k < 4; k++)
      seg_in[k*16 +: 16] = 16'h8000 | 16'(k << 8) | 16'(idx & 255);
    rd_n = 0;
    addr_err = 0;
    sp_i = base; ss_i = ss_in; cpl_i = 2'(hc); seg_i = seg_in; seg_dpl_i = 8'(dpl);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (glitch) begin
      @(negedge clk);
      sp_i = 32'h0000_4000;
      cpl_i = 2'(hc + 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      sp_i = base;
      cpl_i = 2'(hc);
    end
    tmo = 0;
    while (!done_o && tmo < 200) begin
      @(negedge clk);
      tmo++;
    end
    chk("R8 done seen", 64'(done_o), 64'd1);
    chk("R3 ip", 64'(ip_o), 64'(w_ip));
    chk("R3 cs", 64'(cs_o), 64'(w_cs[15:0]));
    chk("R3 flags", 64'(flags_o), 64'(w_fl));
    chk("R6 level", 64'(cpl_o), 64'(rpl));
    chk("R2 addr sequence", 64'(addr_err), 64'd0);
    if (hc == rpl) begin
      chk("R4 reads", 64'(rd_n), 64'd3);
      chk("R4 sp", 64'(sp_o), 64'(base + 32'd12));
      chk("R4 ss", 64'(ss_o), 64'(ss_in));
      chk("R4 segs", seg_o, seg_in);
    end else begin
      chk("R5 reads", 64'(rd_n), 64'd5);
      chk("R5 sp", 64'(sp_o), 64'(w_sp));
      chk("R5 ss", 64'(ss_o), 64'(w_ss[15:0]));
      seg_exp = seg_in;
      for (int k = 0; k < 4; k++)
        if (((dpl >> (2 * k)) & 3) < rpl) seg_exp[k*16 +: 16] = 16'h0000;
      chk("R7 segs", seg_o, seg_exp);
    end
    if (glitch) chk("R9 ignored start", 64'(sp_o == 32'h0000_4000 + 32'd12), 64'd0);
    if (lat > 0) chk("R10 stalled reads", 64'(rd_n == 3 || rd_n == 5), 64'd1);
    @(negedge clk);
    chk("R8 done pulse", 64'(done_o), 64'd0);
    chk("R8 busy drop", 64'(busy_o), 64'd0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    lat = 0;
    rd_n = 0;
    addr_err = 0;
    base = '0;
    for (int m = 0; m < 8; m++) mem[m] = '0;
    rst_n = 1'b0;
    start_i = 1'b0;
    sp_i = '0; ss_i = '0; cpl_i = '0; seg_i = '0; seg_dpl_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 req", 64'(mem_req_o), 64'd0);
    chk("R1 ip", 64'(ip_o), 64'd0);
    chk("R1 sp", 64'(sp_o), 64'd0);
    chk("R1 segs", seg_o, 64'd0);
    chk("R1 level", 64'(cpl_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int hc = 0; hc < 4; hc++)
      for (int rpl = 0; rpl < 4; rpl++)
        for (int dpl = 0; dpl < 256; dpl++)
          run_one(hc, rpl, dpl, hc * 1024 + rpl * 256 + dpl);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule